// File: doc/BRIEF.md
# I2C High-Speed Entry Sequencer

This block sits between the transfer control of an I2C master and its bit-timing generator. It decides how each message opens. When the bus rate requested for a transfer is above the fast-mode limit, the first message does not open directly. The block first sends the reserved master code byte 0x08 under fast-mode timing. It treats the NACK that follows as the normal outcome. It then drops the controller enable for exactly one cycle and issues a repeated START with the high-speed timing set selected.

After that it drives the usual START, READ/WRITE and STOP phases from events reported by the byte engine. It also turns a timeout into a forced STOP that keeps whichever timing set is active. Two complete timing sets come in on ports, each a low divider, a high divider and a packed field of hold and setup counts. The block forwards one of them to the timing generator.

Top module: `hs_entry_seq`

## Requirements
- R1: After reset the block is idle: busy=0, err_code=0, eng_en=0, cmd_start=0, cmd_stop=0, mc_vld=0 and the fast timing set is selected (tim_hs=0).
- R2: A msg_go in idle with msg_first=1 and req_khz strictly above FS_MAX_KHZ (400) enters the master-code phase. One cycle later busy=1, eng_en=1, cmd_start pulses for one cycle, mc_vld=1, mc_byte=0x08 and the fast set is on the timing outputs.
- R3: A NACK event (evt_kind=2) during the master-code phase is not an error. The next cycle has eng_en=0. The cycle after that opens START with cmd_start pulsed and the high-speed set selected (tim_hs=1).
- R4: Any other event (evt_kind 0, 1 or 3) during the master-code phase moves to STOP with cmd_stop pulsed and err_code=2.
- R5: A NACK in START, READ or WRITE moves to STOP with cmd_stop pulsed and err_code=1, unless msg_ign_nack was set at msg_go. In that case the state and all outputs stay unchanged.
- R6: A first message with req_khz at or below 400 opens START directly on the fast set, with no master-code phase.
- R7: A message with msg_first=0 opens START directly and never sends the master code. It uses the speed chosen by the first message of the transfer; req_khz is ignored.
- R8: In START, a started event (evt_kind=0) moves to READ (eng_rd=1) when msg_rd was set, and to WRITE otherwise. In READ or WRITE, a bytes-done event (evt_kind=1) moves to STOP with cmd_stop when msg_last was set. Otherwise it returns to idle and keeps the timing set selected.
- R9: A timeout in any state other than idle and STOP forces STOP with cmd_stop pulsed and err_code=3, and leaves the timing set unchanged. Timeout wins over an event in the same cycle. In STOP, only a stopped event (evt_kind=3) returns to idle, and it restores the fast set.
- R10: busy is 1 exactly when the block is not idle. msg_go while busy and timeout while idle have no effect. err_code holds until the next accepted msg_go clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_go | input | 1 | Start-of-message request pulse |
| msg_first | input | 1 | Message is the first of its transfer |
| msg_rd | input | 1 | Message reads from the target |
| msg_last | input | 1 | Message is the last of its transfer |
| msg_ign_nack | input | 1 | NACKs are ignored for this message |
| req_khz | input | RATE_W | Requested bus rate in kHz |
| evt_vld | input | 1 | Event from the byte engine is valid |
| evt_kind | input | 2 | Event: 0 started, 1 bytes done, 2 NACK, 3 stopped |
| timeout | input | 1 | Transfer timeout pulse |
| fs_div_lo | input | DIV_W | Fast set, low divider |
| fs_div_hi | input | DIV_W | Fast set, high divider |
| fs_cnt | input | CNT_W | Fast set, packed hold/setup counts |
| hs_div_lo | input | DIV_W | High-speed set, low divider |
| hs_div_hi | input | DIV_W | High-speed set, high divider |
| hs_cnt | input | CNT_W | High-speed set, packed hold/setup counts |
| busy | output | 1 | Sequencer not idle |
| err_code | output | 2 | 0 none, 1 NACK, 2 unexpected event, 3 timeout |
| eng_en | output | 1 | Controller enable |
| eng_rd | output | 1 | Engine in read phase |
| cmd_start | output | 1 | One-cycle START / repeated START request |
| cmd_stop | output | 1 | One-cycle STOP request |
| mc_vld | output | 1 | Master code byte is being sent |
| mc_byte | output | 8 | Master code byte (0x08 while mc_vld, else 0) |
| tim_hs | output | 1 | High-speed timing set selected |
| tim_div_lo | output | DIV_W | Selected low divider |
| tim_div_hi | output | DIV_W | Selected high divider |
| tim_cnt | output | CNT_W | Selected packed counts |

## Verification
The bench uses the default widths, RATE_W=12 and FS_MAX_KHZ=400. This puts the fast/high-speed boundary at 400 and 401 kHz, and both values drive the decision. The two timing sets are fed distinct, recognisable divider and count words, so any cycle on the wrong set shows up on the timing outputs. The events come from the bench, so it can land a NACK, a wrong event or a timeout in any chosen cycle of the master-code, gap, data and STOP phases, including a timeout and an event in the same cycle.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MCODE, ST_GAP, ST_START, ST_READ, ST_WRITE, ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NACK    = 2'd1,
    ERR_UNEXP   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } seq_err_t;

  localparam logic [1:0] EV_STARTED = 2'd0;
  localparam logic [1:0] EV_BYTES   = 2'd1;
  localparam logic [1:0] EV_NACK    = 2'd2;
  localparam logic [1:0] EV_STOPPED = 2'd3;

  localparam logic [7:0] MASTER_CODE = 8'h08;

  // strictly above the fast-mode ceiling means high-speed entry
  function automatic logic wants_hs(input logic [31:0] khz, input int unsigned ceil_khz);
    return khz > ceil_khz;
  endfunction

endpackage

// File: rtl/hs_seq_evt.sv
module hs_seq_evt
  import hs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_vld,
  input  logic [1:0] evt_kind,
  output logic       ev_started,
  output logic       ev_bytes,
  output logic       ev_nack,
  output logic       ev_stopped,
  output logic       ev_any
);
  assign ev_any     = evt_vld;
  assign ev_started = evt_vld && (evt_kind == EV_STARTED);
  assign ev_bytes   = evt_vld && (evt_kind == EV_BYTES);
  assign ev_nack    = evt_vld && (evt_kind == EV_NACK);
  assign ev_stopped = evt_vld && (evt_kind == EV_STOPPED);

  AST_EV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |-> $onehot({ev_started, ev_bytes, ev_nack, ev_stopped})); // R4
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_seq_pkg::*;
#(
  parameter int RATE_W     = 12,
  parameter int FS_MAX_KHZ = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_go,
  input  logic              msg_first,
  input  logic              msg_rd,
  input  logic              msg_last,
  input  logic              msg_ign_nack,
  input  logic [RATE_W-1:0] req_khz,
  input  logic              ev_started,
  input  logic              ev_bytes,
  input  logic              ev_nack,
  input  logic              ev_stopped,
  input  logic              ev_any,
  input  logic              timeout,
  output seq_state_t        state,
  output logic              hs_active,
  output logic              cmd_start,
  output logic              cmd_stop,
  output seq_err_t          err
);
  seq_state_t nxt;
  seq_err_t   nerr;
  logic hs_mode, rd_q, last_q, ign_q;
  logic n_hs, n_mode, n_start, n_stop, hs_req, nack_ends, take_to;

  assign hs_req    = wants_hs(32'(req_khz), FS_MAX_KHZ);
  assign nack_ends = ev_nack && !ign_q;
  assign take_to   = timeout && (state != ST_IDLE) && (state != ST_STOP);

  always_comb begin
    nxt = state; nerr = err; n_hs = hs_active; n_mode = hs_mode;
    n_start = 1'b0; n_stop = 1'b0;
    if (take_to) begin
      nxt = ST_STOP; nerr = ERR_TIMEOUT; n_stop = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (msg_go) begin
          nerr = ERR_NONE; n_start = 1'b1; nxt = ST_START;
          if (msg_first) begin
            n_mode = hs_req; n_hs = 1'b0;
            if (hs_req) nxt = ST_MCODE;
          end else begin
            n_hs = hs_mode;
          end
        end
        ST_MCODE: if (ev_nack) nxt = ST_GAP;
          else if (ev_any) begin nxt = ST_STOP; nerr = ERR_UNEXP; n_stop = 1'b1; end
        ST_GAP: begin nxt = ST_START; n_hs = 1'b1; n_start = 1'b1; end
        ST_START: if (nack_ends) begin nxt = ST_STOP; nerr = ERR_NACK; n_stop = 1'b1; end
          else if (ev_started) nxt = rd_q ? ST_READ : ST_WRITE;
        ST_READ, ST_WRITE:
          if (nack_ends) begin nxt = ST_STOP; nerr = ERR_NACK; n_stop = 1'b1; end
          else if (ev_bytes) begin
            if (last_q) begin nxt = ST_STOP; n_stop = 1'b1; end
            else nxt = ST_IDLE;
          end
        ST_STOP: if (ev_stopped) begin nxt = ST_IDLE; n_hs = 1'b0; end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; err <= ERR_NONE; hs_active <= 1'b0; hs_mode <= 1'b0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0;
      rd_q <= 1'b0; last_q <= 1'b0; ign_q <= 1'b0;
    end else begin
      state <= nxt; err <= nerr; hs_active <= n_hs; hs_mode <= n_mode;
      cmd_start <= n_start; cmd_stop <= n_stop;
      if (state == ST_IDLE && msg_go) begin
        rd_q <= msg_rd; last_q <= msg_last; ign_q <= msg_ign_nack;
      end
    end
  end

  AST_MC_ON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MCODE) |-> !hs_active); // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_start && cmd_stop)); // R8
  AST_MC_NACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MCODE && ev_nack && !timeout) |=> (state == ST_GAP)); // R3
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && !timeout) |=> (state == ST_START && hs_active && cmd_start)); // R3
  AST_MC_UNEXP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MCODE && ev_any && !ev_nack && !timeout)
      |=> (state == ST_STOP && err == ERR_UNEXP && cmd_stop)); // R4
  AST_IGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && ign_q && !timeout && (state == ST_READ || state == ST_WRITE))
      |=> $stable(state)); // R5
  AST_TIMEOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && state != ST_IDLE && state != ST_STOP)
      |=> (state == ST_STOP && err == ERR_TIMEOUT && $stable(hs_active))); // R9
endmodule

// File: rtl/hs_tim_mux.sv
module hs_tim_mux #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 7
) (
  input  logic             sel_hs,
  input  logic [DIV_W-1:0] fs_div_lo,
  input  logic [DIV_W-1:0] fs_div_hi,
  input  logic [CNT_W-1:0] fs_cnt,
  input  logic [DIV_W-1:0] hs_div_lo,
  input  logic [DIV_W-1:0] hs_div_hi,
  input  logic [CNT_W-1:0] hs_cnt,
  output logic [DIV_W-1:0] out_div_lo,
  output logic [DIV_W-1:0] out_div_hi,
  output logic [CNT_W-1:0] out_cnt
);
  localparam int SET_W = 2 * DIV_W + CNT_W;
  logic [SET_W-1:0] set_fs, set_hs, set_out;

  assign set_fs  = {fs_div_hi, fs_div_lo, fs_cnt};
  assign set_hs  = {hs_div_hi, hs_div_lo, hs_cnt};
  assign set_out = sel_hs ? set_hs : set_fs;
  assign {out_div_hi, out_div_lo, out_cnt} = set_out;
endmodule

// File: rtl/hs_entry_seq.sv
module hs_entry_seq
  import hs_seq_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 7,
  parameter int RATE_W     = 12,
  parameter int FS_MAX_KHZ = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_go,
  input  logic              msg_first,
  input  logic              msg_rd,
  input  logic              msg_last,
  input  logic              msg_ign_nack,
  input  logic [RATE_W-1:0] req_khz,
  input  logic              evt_vld,
  input  logic [1:0]        evt_kind,
  input  logic              timeout,
  input  logic [DIV_W-1:0]  fs_div_lo,
  input  logic [DIV_W-1:0]  fs_div_hi,
  input  logic [CNT_W-1:0]  fs_cnt,
  input  logic [DIV_W-1:0]  hs_div_lo,
  input  logic [DIV_W-1:0]  hs_div_hi,
  input  logic [CNT_W-1:0]  hs_cnt,
  output logic              busy,
  output logic [1:0]        err_code,
  output logic              eng_en,
  output logic              eng_rd,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              mc_vld,
  output logic [7:0]        mc_byte,
  output logic              tim_hs,
  output logic [DIV_W-1:0]  tim_div_lo,
  output logic [DIV_W-1:0]  tim_div_hi,
  output logic [CNT_W-1:0]  tim_cnt
);
  logic ev_started, ev_bytes, ev_nack, ev_stopped, ev_any, hs_active;
  seq_state_t state;
  seq_err_t   err;

  hs_seq_evt u_evt (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_kind(evt_kind),
    .ev_started(ev_started), .ev_bytes(ev_bytes), .ev_nack(ev_nack),
    .ev_stopped(ev_stopped), .ev_any(ev_any)
  );

  hs_seq_fsm #(.RATE_W(RATE_W), .FS_MAX_KHZ(FS_MAX_KHZ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .msg_go(msg_go), .msg_first(msg_first),
    .msg_rd(msg_rd), .msg_last(msg_last), .msg_ign_nack(msg_ign_nack),
    .req_khz(req_khz), .ev_started(ev_started), .ev_bytes(ev_bytes),
    .ev_nack(ev_nack), .ev_stopped(ev_stopped), .ev_any(ev_any),
    .timeout(timeout), .state(state), .hs_active(hs_active),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .err(err)
  );

  hs_tim_mux #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_mux (
    .sel_hs(hs_active), .fs_div_lo(fs_div_lo), .fs_div_hi(fs_div_hi),
    .fs_cnt(fs_cnt), .hs_div_lo(hs_div_lo), .hs_div_hi(hs_div_hi),
    .hs_cnt(hs_cnt), .out_div_lo(tim_div_lo), .out_div_hi(tim_div_hi),
    .out_cnt(tim_cnt)
  );

  assign busy     = (state != ST_IDLE);
  assign err_code = err;
  assign eng_en   = (state != ST_IDLE) && (state != ST_GAP);
  assign eng_rd   = (state == ST_READ);
  assign mc_vld   = (state == ST_MCODE);
  assign mc_byte  = mc_vld ? MASTER_CODE : 8'h00;
  assign tim_hs   = hs_active;

  AST_BUSY_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !msg_go) |=> $stable(err_code)); // R10
endmodule

// File: tb/sim_hs_entry_seq.sv
module sim_hs_entry_seq;
  localparam int DIV_W = 16, CNT_W = 7, RATE_W = 12;
  localparam logic [DIV_W-1:0] FS_LO = 16'h0031, FS_HI = 16'h0022;
  localparam logic [DIV_W-1:0] HS_LO = 16'h0005, HS_HI = 16'h0003;
  localparam logic [CNT_W-1:0] FS_C = 7'h2A, HS_C = 7'h15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i_go = 0, i_first = 0, i_rd = 0, i_last = 0, i_ign = 0, i_ev = 0, i_to = 0;
  logic [RATE_W-1:0] i_khz = '0;
  logic [1:0] i_kind = '0;
  logic busy, eng_en, eng_rd, cmd_start, cmd_stop, mc_vld, tim_hs;
  logic [1:0] err_code;
  logic [7:0] mc_byte;
  logic [DIV_W-1:0] tim_div_lo, tim_div_hi;
  logic [CNT_W-1:0] tim_cnt;

  always #5 clk = ~clk;

  hs_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .msg_go(i_go), .msg_first(i_first), .msg_rd(i_rd),
    .msg_last(i_last), .msg_ign_nack(i_ign), .req_khz(i_khz), .evt_vld(i_ev),
    .evt_kind(i_kind), .timeout(i_to), .fs_div_lo(FS_LO), .fs_div_hi(FS_HI),
    .fs_cnt(FS_C), .hs_div_lo(HS_LO), .hs_div_hi(HS_HI), .hs_cnt(HS_C),
    .busy(busy), .err_code(err_code), .eng_en(eng_en), .eng_rd(eng_rd),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .mc_vld(mc_vld), .mc_byte(mc_byte),
    .tim_hs(tim_hs), .tim_div_lo(tim_div_lo), .tim_div_hi(tim_div_hi), .tim_cnt(tim_cnt)
  );

  // reference model: 0 idle, 1 master code, 2 gap, 3 start, 4 read, 5 write, 6 stop
  int ms = 0, merr = 0;
  bit mhs = 0, mmode = 0, mstart = 0, mstop = 0, mrd = 0, mlast = 0, mign = 0;
  int vectors = 0, miss = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, f, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("busy", 32'(busy), 32'(ms != 0));
    chk("err_code", 32'(err_code), 32'(merr));
    chk("eng_en", 32'(eng_en), 32'(ms != 0 && ms != 2));
    chk("eng_rd", 32'(eng_rd), 32'(ms == 4));
    chk("cmd_start", 32'(cmd_start), 32'(mstart));
    chk("cmd_stop", 32'(cmd_stop), 32'(mstop));
    chk("mc_vld", 32'(mc_vld), 32'(ms == 1));
    chk("mc_byte", 32'(mc_byte), (ms == 1) ? 32'h08 : 32'h0);
    chk("tim_hs", 32'(tim_hs), 32'(mhs));
    chk("tim_div_lo", 32'(tim_div_lo), 32'(mhs ? HS_LO : FS_LO));
    chk("tim_div_hi", 32'(tim_div_hi), 32'(mhs ? HS_HI : FS_HI));
    chk("tim_cnt", 32'(tim_cnt), 32'(mhs ? HS_C : FS_C));
  endtask

  task automatic model_step();
    mstart = 0; mstop = 0;
    if (i_to && ms != 0 && ms != 6) begin
      ms = 6; merr = 3; mstop = 1;
    end else if (ms == 0) begin
      if (i_go) begin
        merr = 0; mstart = 1; mrd = i_rd; mlast = i_last; mign = i_ign;
        if (i_first) begin mmode = (i_khz > 400); mhs = 0; ms = mmode ? 1 : 3; end
        else begin mhs = mmode; ms = 3; end
      end
    end else if (ms == 1) begin
      if (i_ev) begin
        if (i_kind == 2) ms = 2;
        else begin ms = 6; merr = 2; mstop = 1; end
      end
    end else if (ms == 2) begin
      ms = 3; mhs = 1; mstart = 1;
    end else if (ms == 6) begin
      if (i_ev && i_kind == 3) begin ms = 0; mhs = 0; end
    end else begin
      if (i_ev && i_kind == 2 && !mign) begin ms = 6; merr = 1; mstop = 1; end
      else if (ms == 3 && i_ev && i_kind == 0) ms = mrd ? 4 : 5;
      else if (ms != 3 && i_ev && i_kind == 1) begin
        if (mlast) begin ms = 6; mstop = 1; end else ms = 0;
      end
    end
  endtask

  task automatic step();
    @(posedge clk); model_step();
    @(negedge clk); compare_all();
  endtask

  task automatic go(bit first, int khz, bit rd, bit last, bit ign);
    i_go = 1; i_first = first; i_khz = RATE_W'(khz); i_rd = rd; i_last = last; i_ign = ign;
    step();
    i_go = 0; i_first = 0; i_rd = 0; i_last = 0; i_ign = 0;
  endtask

  task automatic ev(int kind);
    i_ev = 1; i_kind = 2'(kind); step(); i_ev = 0;
  endtask

  task automatic tmo(bit with_ev, int kind);
    i_to = 1; i_ev = with_ev; i_kind = 2'(kind); step(); i_to = 0; i_ev = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; compare_all();
    idle(2);

    cur_req = "R2"; go(1, 1700, 0, 1, 0); idle(1);
    cur_req = "R3"; ev(2); step(); idle(1);
    cur_req = "R8"; ev(0); ev(1); ev(3);

    cur_req = "R4"; go(1, 3400, 0, 1, 0); ev(0); idle(1); ev(3);
    cur_req = "R4"; go(1, 3400, 0, 1, 0); ev(3); ev(3);

    cur_req = "R6"; go(1, 400, 1, 0, 0);
    cur_req = "R8"; ev(0); ev(1);
    cur_req = "R7"; go(0, 3000, 0, 1, 0); ev(0);
    cur_req = "R5"; ev(2); ev(3);

    cur_req = "R6"; go(1, 401, 0, 0, 0); ev(2); step();
    cur_req = "R8"; ev(0); ev(1); idle(1);
    cur_req = "R7"; go(0, 100, 1, 1, 1);
    cur_req = "R5"; ev(2); ev(0); ev(2); idle(1);
    cur_req = "R9"; tmo(1, 1); tmo(0, 0); ev(0); ev(1); ev(2); ev(3);

    cur_req = "R9"; go(1, 1000, 0, 1, 0); tmo(0, 0); ev(3);
    cur_req = "R9"; go(1, 1000, 0, 1, 0); ev(2); tmo(0, 0); ev(3);
    cur_req = "R10"; tmo(0, 0); idle(2);
    cur_req = "R10"; go(1, 200, 0, 1, 0); go(1, 2000, 1, 0, 0); ev(0);
    cur_req = "R10"; go(0, 2000, 1, 0, 0); ev(1); ev(3); go(0, 50, 0, 1, 0);
    cur_req = "R9"; tmo(1, 2); ev(3);
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule